// File: doc/BRIEF.md
# Cascadable Configurable Logic Cell Pair

This block contains two identical small logic cells. Each cell takes three single-bit inputs, called A, B and C, and can invert each of them on its own. It then produces one result, chosen by a three-bit function code from these options:

- constant off;
- three-input AND, OR or XOR;
- a state bit clocked by the B input and cleared by the C input;
- a direct tap of one of the three conditioned inputs.

The chosen result can also be inverted before it leaves the cell. Each cell is set up by one configuration byte.

The second cell can take the first cell's final output in place of its own A pin. This lets the two cells be chained to build a wider function. All paths except the state bit are combinational.

The state bit is kept in the system clock domain. On each clock edge the conditioned B input is compared with its value at the previous edge. A low-to-high change loads the conditioned A input. A high conditioned C input forces the cell's visible result low at once and empties the stored bit.

Top module: `lc_pair`

## Requirements
- R1: While reset is held and on the first cycle after it, the stored bit of both cells is 0, so with both configuration bytes at 0x00 both outputs read 0.
- R2: Function code 000 (bits 2:0) makes the cell result 0 before output inversion, so the output equals the output-invert bit (bit 6).
- R3: Codes 001, 010 and 011 give the AND, OR and XOR of the three conditioned inputs, in the same cycle.
- R4: Codes 101, 110 and 111 pass the conditioned A, B or C input, respectively, to the result in the same cycle.
- R5: With code 100, at a clock edge where the conditioned B is 1 and was 0 at the previous edge, the conditioned A is stored. The result shows the stored bit from the cycle after that edge.
- R6: With code 100, a conditioned C of 1 forces the result to 0 in the same cycle and empties the stored bit. When C is high at a B rising edge, the clear wins over the load.
- R7: Bits 3, 4 and 5 invert the A, B and C inputs before use. Bit 6 inverts the cell result.
- R8: In the second cell's byte, bit 7 set replaces that cell's A pin with the first cell's final (post-inversion) output. Bit 7 of the first cell's byte has no effect.
- R9: The B edge detector leaves reset as if B had been high, so a B input held high through reset loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_lo | input | 8 | First cell configuration byte |
| cfg_hi | input | 8 | Second cell configuration byte (bit 7 = chain) |
| a1 | input | 1 | First cell A input |
| b1 | input | 1 | First cell B input |
| c1 | input | 1 | First cell C input |
| a2 | input | 1 | Second cell A input |
| b2 | input | 1 | Second cell B input |
| c2 | input | 1 | Second cell C input |
| y1 | output | 1 | First cell result |
| y2 | output | 1 | Second cell result |

## Verification
Gate, tap, off and clear results are due in the same cycle as the input change. A stored-bit load is due one clock edge after the B rise is seen. The bench therefore drives at the falling edge and compares just before the next rising edge, so that every combinational result has settled and any load from the previous edge is already visible. Its behavioural model advances its stored bits only after each comparison, at the point the design's clock edge follows. Short directed sequences pin the load latency, the clear priority and the reset behaviour with literal expected values.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int N_CELLS = 2;

    typedef enum logic [2:0] {
        FN_OFF   = 3'b000,
        FN_AND   = 3'b001,
        FN_OR    = 3'b010,
        FN_XOR   = 3'b011,
        FN_HOLD  = 3'b100,
        FN_TAP_A = 3'b101,
        FN_TAP_B = 3'b110,
        FN_TAP_C = 3'b111
    } fn_e;

    typedef struct packed {
        logic chain;   // bit 7
        logic inv_y;   // bit 6
        logic inv_c;   // bit 5
        logic inv_b;   // bit 4
        logic inv_a;   // bit 3
        fn_e  fn;      // bits 2:0
    } cell_cfg_t;

    localparam int CFG_W = $bits(cell_cfg_t);

    typedef struct packed {
        logic a;
        logic b;
        logic c;
    } trio_t;

    function automatic trio_t condition(input trio_t raw, input cell_cfg_t cfg);
        trio_t m;
        m.a = raw.a ^ cfg.inv_a;
        m.b = raw.b ^ cfg.inv_b;
        m.c = raw.c ^ cfg.inv_c;
        return m;
    endfunction

endpackage

// File: rtl/lc_hold.sv
module lc_hold (
    input  logic clk,
    input  logic rst,
    input  logic d,
    input  logic strobe,
    input  logic clr,
    output logic q
);
    logic stored;
    logic strobe_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stored      <= 1'b0;
            strobe_prev <= 1'b1;
        end else begin
            strobe_prev <= strobe;
            if (clr)
                stored <= 1'b0;
            else if (strobe && !strobe_prev)
                stored <= d;
        end
    end

    assign q = clr ? 1'b0 : stored;
endmodule

// File: rtl/lc_cell.sv
module lc_cell
    import lc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_cfg_t cfg,
    input  trio_t     raw,
    output logic      y
);
    trio_t m;
    logic  hold_q;
    logic  core;

    assign m = condition(raw, cfg);

    lc_hold u_hold (
        .clk    (clk),
        .rst    (rst),
        .d      (m.a),
        .strobe (m.b),
        .clr    (m.c),
        .q      (hold_q)
    );

    always_comb begin
        unique case (cfg.fn)
            FN_OFF:   core = 1'b0;
            FN_AND:   core = m.a & m.b & m.c;
            FN_OR:    core = m.a | m.b | m.c;
            FN_XOR:   core = m.a ^ m.b ^ m.c;
            FN_HOLD:  core = hold_q;
            FN_TAP_A: core = m.a;
            FN_TAP_B: core = m.b;
            FN_TAP_C: core = m.c;
            default:  core = 1'b0;
        endcase
    end

    assign y = core ^ cfg.inv_y;
endmodule

// File: rtl/lc_pair.sv
module lc_pair
    import lc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] cfg_lo,
    input  logic [7:0] cfg_hi,
    input  logic       a1,
    input  logic       b1,
    input  logic       c1,
    input  logic       a2,
    input  logic       b2,
    input  logic       c2,
    output logic       y1,
    output logic       y2
);
    cell_cfg_t cfg_arr [N_CELLS];
    trio_t     pin_arr [N_CELLS];

    assign cfg_arr[0] = cell_cfg_t'(cfg_lo[CFG_W-1:0]);
    assign cfg_arr[1] = cell_cfg_t'(cfg_hi[CFG_W-1:0]);
    assign pin_arr[0] = '{a: a1, b: b1, c: c1};
    assign pin_arr[1] = '{a: a2, b: b2, c: c2};

    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        trio_t raw;
        logic  y_loc;
        if (i == 0) begin : g_head
            assign raw = pin_arr[i];
        end else begin : g_link
            assign raw.a = cfg_arr[i].chain ? g_cell[i-1].y_loc : pin_arr[i].a;
            assign raw.b = pin_arr[i].b;
            assign raw.c = pin_arr[i].c;
        end
        lc_cell u_cell (
            .clk (clk),
            .rst (rst),
            .cfg (cfg_arr[i]),
            .raw (raw),
            .y   (y_loc)
        );
    end

    assign y1 = g_cell[0].y_loc;
    assign y2 = g_cell[1].y_loc;
endmodule

// File: rtl/lc_pair_chk.sv
module lc_pair_chk (
    input logic       clk,
    input logic       rst,
    input logic [7:0] cfg_lo,
    input logic [7:0] cfg_hi,
    input logic       a1,
    input logic       b1,
    input logic       c1,
    input logic       a2,
    input logic       y1,
    input logic       y2
);
    logic am1, bm1, cm1, bm1_q, armed;

    assign am1 = a1 ^ cfg_lo[3];
    assign bm1 = b1 ^ cfg_lo[4];
    assign cm1 = c1 ^ cfg_lo[5];

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
        bm1_q <= bm1;
    end

    // R2
    off_level_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_lo[2:0] == 3'b000) |-> (y1 == cfg_lo[6]));

    // R4
    tap_a_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_lo[2:0] == 3'b101) |-> (y1 == (am1 ^ cfg_lo[6])));

    // R6
    hold_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_lo[2:0] == 3'b100 && cm1) |-> (y1 == cfg_lo[6]));

    // R5
    hold_load_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && cfg_lo[2:0] == 3'b100 && bm1 && !bm1_q && !cm1)
        |=> ((cfg_lo[2:0] == 3'b100 && !cm1) -> (y1 == ($past(am1) ^ cfg_lo[6]))));

    // R8
    chain_tap_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_hi[7] && cfg_hi[2:0] == 3'b101) |-> (y2 == (y1 ^ cfg_hi[3] ^ cfg_hi[6])));
endmodule

bind lc_pair lc_pair_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cfg_lo (cfg_lo),
    .cfg_hi (cfg_hi),
    .a1     (a1),
    .b1     (b1),
    .c1     (c1),
    .a2     (a2),
    .y1     (y1),
    .y2     (y2)
);

// File: tb/lc_pair_test.sv
`timescale 1ns/1ps
module lc_pair_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] cfg_lo = 8'h00, cfg_hi = 8'h00;
    logic a1 = 0, b1 = 0, c1 = 0, a2 = 0, b2 = 0, c2 = 0;
    logic y1, y2;

    int checks = 0;
    int fails  = 0;

    bit q_m [2];
    bit p_m [2];

    always #5 clk = ~clk;

    lc_pair uut (
        .clk(clk), .rst(rst), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .a1(a1), .b1(b1), .c1(c1), .a2(a2), .b2(b2), .c2(c2),
        .y1(y1), .y2(y2)
    );

    function automatic bit ref_out(input logic [7:0] cf, input bit a, input bit b,
                                   input bit c, input bit q);
        bit ma = a ^ cf[3];
        bit mb = b ^ cf[4];
        bit mc = c ^ cf[5];
        bit r;
        case (cf[2:0])
            3'd0: r = 0;
            3'd1: r = ma && mb && mc;
            3'd2: r = ma || mb || mc;
            3'd3: r = ma ^ mb ^ mc;
            3'd4: r = mc ? 0 : q;
            3'd5: r = ma;
            3'd6: r = mb;
            default: r = mc;
        endcase
        return r ^ cf[6];
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        if (s == 3'd0) return "R2";
        if (s == 3'd4) return "R5/R6";
        if (s >= 3'd5) return "R4";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            q_m[i] = 0;
            p_m[i] = 1;
        end
    endtask

    task automatic model_edge(input int i, input logic [7:0] cf, input bit a,
                              input bit b, input bit c);
        bit ma = a ^ cf[3];
        bit mb = b ^ cf[4];
        bit mc = c ^ cf[5];
        if (mc) q_m[i] = 0;
        else if (mb && !p_m[i]) q_m[i] = ma;
        p_m[i] = mb;
    endtask

    // Called at a falling edge: drive, compare before the next rising edge, advance model.
    task automatic step(input logic [7:0] c1v, input logic [7:0] c2v,
                        input logic [5:0] ins, input string tag);
        bit e1, e2, a2e;
        cfg_lo = c1v; cfg_hi = c2v;
        {a1, b1, c1, a2, b2, c2} = ins;
        #4;
        e1  = ref_out(c1v, a1, b1, c1, q_m[0]);
        a2e = c2v[7] ? e1 : a2;
        e2  = ref_out(c2v, a2e, b2, c2, q_m[1]);
        check({tag, " y1"}, y1, e1);
        check({tag, c2v[7] ? " y2 chained R8" : " y2"}, y2, e2);
        if (!rst) begin
            model_edge(0, c1v, a1, b1, c1);
            model_edge(1, c2v, a2e, b2, c2);
        end
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [5:0] ins);
        rst = 1'b1;
        {a1, b1, c1, a2, b2, c2} = ins;
        repeat (2) @(negedge clk);
        model_reset();
        rst = 1'b0;
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset(6'b0);
        // R1: quiet outputs right after reset
        #4;
        check("R1 y1 after reset", y1, 1'b0);
        check("R1 y2 after reset", y2, 1'b0);
        @(negedge clk);

        // R5: literal load latency on cell 1
        step(8'h04, 8'h00, 6'b100000, "R5 idle");
        step(8'h04, 8'h00, 6'b110000, "R5 rise");
        #4; check("R5 loaded one edge later", y1, 1'b1); @(negedge clk);
        // R6: clear is immediate and empties the bit
        step(8'h04, 8'h00, 6'b101000, "R6 clear");
        #4; check("R6 stays cleared", y1, 1'b0); @(negedge clk);
        // R6: clear wins over a simultaneous B rise
        step(8'h04, 8'h00, 6'b100000, "R6 prep");
        step(8'h04, 8'h00, 6'b111000, "R6 clear+rise");
        #4; check("R6 clear priority", y1, 1'b0); @(negedge clk);
        // R7: inverted B and A, load on falling raw B
        step(8'h1C, 8'h00, 6'b010000, "R7 prep");
        step(8'h1C, 8'h00, 6'b000000, "R7 inv rise");
        #4; check("R7 inverted A loaded", y1, 1'b1); @(negedge clk);
        // R2: off with output invert is high
        step(8'h40, 8'h40, 6'b111111, "R2 off inv");
        // R8: bit 7 of first byte ignored; chain uses post-inversion y1
        step(8'h80 | 8'h45, 8'h85, 6'b000000, "R8 chain inv");
        #4; check("R8 chained y2", y2, 1'b1); @(negedge clk);

        // R9: B held high through reset loads nothing
        do_reset(6'b110110);
        cfg_lo = 8'h04; cfg_hi = 8'h04;
        step(8'h04, 8'h04, 6'b110110, "R9 first");
        #4; check("R9 y1 no load", y1, 1'b0);
        check("R9 y2 no load", y2, 1'b0); @(negedge clk);

        // Exhaustive sweep of cell 1 byte, R3/R4/R7 with varied cell 2
        for (int cf = 0; cf < 256; cf++) begin
            for (int k = 0; k < 8; k++) begin
                logic [7:0] c2v = 8'(cf) ^ 8'hA5;
                step(8'(cf), c2v, {3'(k), 3'(~k)}, tag_of(3'(cf)));
            end
        end

        // Random streams, hold-heavy, chained and unchained
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] c1v = 8'($urandom);
            logic [7:0] c2v = 8'($urandom);
            if (n % 2 == 0) c1v[2:0] = 3'd4;
            if (n % 3 != 0) c2v[2:0] = 3'd4;
            c1v = (n < 1500) ? {c1v[7:6], 3'b000, c1v[2:0]} : c1v;
            c2v[7] = (n >= 1000 && n < 2500);
            if (n % 50 < 40) begin c1v = 8'h04; c2v = {c2v[7], 7'h04}; end
            step(c1v, c2v, 6'($urandom), tag_of(c1v[2:0]));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule